// File: doc/BRIEF.md
# Multi-register parameter commit sequencer

This block keeps configuration parameters wider than one byte consistent while software writes them one byte register at a time. Each wide parameter occupies a run of consecutive byte addresses. Bytes written to such a run are collected in a private staging buffer, and the parameter seen by the rest of the chip keeps its old value. Only when the highest address of the run is written, as part of an unbroken ascending sequence, are all of its bits transferred to the live value together. A one-cycle pulse marks that transfer.

The block sits behind the register bus decoder. It receives per-cycle write and read strobes with an address and a data byte. It returns read data for its own addresses and presents every committed parameter on a flat output vector. The table of grouped parameters is fixed in a package. Bus framing and all other registers belong to the surrounding register file.

Top module: `wide_param_sync`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `commit_pulse` is zero and the live values are the defaults: group 0 = 0xABC, group 1 = 0x12345, group 2 = 0xBEEF. No sequence is in progress after reset.
- R2: The group table is as follows. Group 0 spans addresses 0x34–0x35 and is 12 bits wide. Group 1 spans 0x40–0x42 and is 20 bits wide. Group 2 spans 0x50–0x51 and is 16 bits wide. The bytes of a group are concatenated with the lowest address as the most significant byte, and the result is truncated to the group width. Group g appears on `params[24*g +: 24]`, zero-extended.
- R3: A live value never changes in a cycle in which its `commit_pulse` bit was not raised. Bytes of a sequence that is not yet complete are not visible on `params`.
- R4: When the final address of a group is written while that group's sequence is complete up to it, the new value appears on `params` at that clock edge. `commit_pulse[g]` is high for exactly the following cycle.
- R5: A sequence starts with a write to the lowest address of a group. It advances only on a write to the next higher address of the same group. Cycles with neither strobe do not affect it.
- R6: Any other access after a sequence has started aborts it and discards the staged bytes. Such an access may be a read, a write to another address, or a cycle with both strobes high. An aborting write to the lowest address of a group starts a new sequence.
- R7: A write to a non-first address of a group with no matching sequence in progress commits nothing and changes no live value.
- R8: While `rd_en` is high, `rdata` is driven combinationally in the same cycle. It carries the byte of the committed live value at that address, never a staged byte. Addresses outside the table read as 0.
- R9: At most one bit of `commit_pulse` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| addr | input | 8 | Byte register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, committed value byte |
| params | output | 72 | Live parameters, 24 bits per group |
| commit_pulse | output | 3 | One-cycle commit indication per group |

## Verification
Suppose the sequence tracker holds a stale group or byte index. The wrong result reaches the ports at the next write: either a parameter that should have committed stays unchanged with no pulse, or a value commits after a broken or out-of-order sequence. Both show on `params` and `commit_pulse` one cycle after the final write. A corrupted staging byte only becomes visible in the committed value at the end of the sequence, so every sequence is followed through to its commit and checked. Reads taken in the middle of a sequence expose any leak of staged data into the read path in the same cycle.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int NUM_GRP   = 3;
  localparam int MAX_BYTES = 3;
  localparam int SLOT_W    = MAX_BYTES * DATA_W;
  localparam int GRP_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int IDX_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic             hit;
    logic [GRP_W-1:0] grp;
    logic [IDX_W-1:0] idx;
    logic             first;
    logic             last;
  } dec_t;

  function automatic logic [ADDR_W-1:0] grp_base(input int g);
    case (g)
      0:       return 8'h34;
      1:       return 8'h40;
      default: return 8'h50;
    endcase
  endfunction

  function automatic int grp_bytes(input int g);
    case (g)
      0:       return 2;
      1:       return 3;
      default: return 2;
    endcase
  endfunction

  function automatic int grp_width(input int g);
    case (g)
      0:       return 12;
      1:       return 20;
      default: return 16;
    endcase
  endfunction

  function automatic slot_t grp_default(input int g);
    case (g)
      0:       return 24'h000ABC;
      1:       return 24'h012345;
      default: return 24'h00BEEF;
    endcase
  endfunction

  function automatic slot_t width_mask(input int g);
    slot_t one;
    one = slot_t'(1);
    return (one << grp_width(g)) - one;
  endfunction
endpackage

// File: rtl/wps_decode.sv
module wps_decode
  import wps_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  always_comb begin
    dec = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int k = 0; k < MAX_BYTES; k++) begin
        if ((k < grp_bytes(g)) && (addr == grp_base(g) + ADDR_W'(k))) begin
          dec.hit   = 1'b1;
          dec.grp   = GRP_W'(g);
          dec.idx   = IDX_W'(k);
          dec.first = (k == 0);
          dec.last  = (k == grp_bytes(g) - 1);
        end
      end
    end
  end
endmodule

// File: rtl/wps_seq.sv
module wps_seq
  import wps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  byte_t            wdata,
  input  dec_t             dec,
  output logic             commit_stb,
  output logic [GRP_W-1:0] commit_grp,
  output slot_t            commit_val
);
  logic                  active_q, active_d;
  logic [GRP_W-1:0]      grp_q, grp_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  byte_t [MAX_BYTES-1:0] stage_q, stage_d;
  logic                  wr_only, any_acc, follow, state_en;
  slot_t                 acc;

  // next state of the tracker
  always_comb begin
    wr_only    = wr_en & ~rd_en;
    any_acc    = wr_en | rd_en;
    state_en   = any_acc;
    follow     = active_q & wr_only & dec.hit & (dec.grp == grp_q) & (dec.idx == idx_q);
    active_d   = active_q;
    grp_d      = grp_q;
    idx_d      = idx_q;
    stage_d    = stage_q;
    commit_stb = 1'b0;
    if (follow) begin
      stage_d[idx_q] = wdata;
      if (dec.last) begin
        commit_stb = 1'b1;
        active_d   = 1'b0;
        idx_d      = '0;
        stage_d    = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end else if (any_acc) begin
      active_d = 1'b0;
      idx_d    = '0;
      stage_d  = '0;
      if (wr_only & dec.hit & dec.first) begin
        active_d   = 1'b1;
        grp_d      = dec.grp;
        idx_d      = IDX_W'(1);
        stage_d[0] = wdata;
      end
    end
  end

  // value assembled from staged bytes plus the byte written now
  always_comb begin
    acc = '0;
    for (int k = 0; k < MAX_BYTES; k++) begin
      if (k < grp_bytes(int'(grp_q))) begin
        acc = (acc << DATA_W) | slot_t'((IDX_W'(k) == idx_q) ? wdata : stage_q[k]);
      end
    end
    commit_val = acc & width_mask(int'(grp_q));
    commit_grp = grp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      grp_q    <= '0;
      idx_q    <= '0;
      stage_q  <= '0;
    end else if (state_en) begin
      active_q <= active_d;
      grp_q    <= grp_d;
      idx_q    <= idx_d;
      stage_q  <= stage_d;
    end
  end
endmodule

// File: rtl/wps_live.sv
module wps_live
  import wps_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit_stb,
  input  logic [GRP_W-1:0]           commit_grp,
  input  slot_t                      commit_val,
  input  dec_t                       dec,
  output byte_t                      rdata,
  output logic [NUM_GRP*SLOT_W-1:0]  params,
  output logic [NUM_GRP-1:0]         commit_pulse
);
  slot_t live_arr [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
    logic  load;
    slot_t live_q;
    logic  pulse_q;

    always_comb begin
      load = commit_stb && (commit_grp == GRP_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q  <= grp_default(g);
        pulse_q <= 1'b0;
      end else begin
        pulse_q <= load;
        if (load) begin
          live_q <= commit_val;
        end
      end
    end

    assign live_arr[g]                   = live_q;
    assign params[g*SLOT_W +: SLOT_W]    = live_q;
    assign commit_pulse[g]               = pulse_q;
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (dec.hit && (dec.grp == GRP_W'(g))) begin
        rdata = byte_t'(live_arr[g] >> (DATA_W * (grp_bytes(g) - 1 - int'(dec.idx))));
      end
    end
  end
endmodule

// File: rtl/wide_param_sync.sv
module wide_param_sync
  import wps_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_GRP*SLOT_W-1:0] params,
  output logic [NUM_GRP-1:0]        commit_pulse
);
  dec_t             dec;
  logic             commit_stb;
  logic [GRP_W-1:0] commit_grp;
  slot_t            commit_val;

  wps_decode u_decode (
    .addr (addr),
    .dec  (dec)
  );

  wps_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .dec        (dec),
    .commit_stb (commit_stb),
    .commit_grp (commit_grp),
    .commit_val (commit_val)
  );

  wps_live u_live (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_stb   (commit_stb),
    .commit_grp   (commit_grp),
    .commit_val   (commit_val),
    .dec          (dec),
    .rdata        (rdata),
    .params       (params),
    .commit_pulse (commit_pulse)
  );
endmodule

// File: rtl/wps_checker.sv
module wps_checker
  import wps_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [NUM_GRP*SLOT_W-1:0] params,
  input logic [NUM_GRP-1:0]        commit_pulse
);
  function automatic logic is_last_addr(input logic [ADDR_W-1:0] a);
    logic r;
    r = 1'b0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (a == grp_base(g) + ADDR_W'(grp_bytes(g) - 1)) r = 1'b1;
    end
    return r;
  endfunction

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_pulse));

  assert_hold_without_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse == '0) |-> $stable(params));

  assert_pulse_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse != '0) |-> $past(wr_en && !rd_en));

  assert_pulse_at_final_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse != '0) |-> is_last_addr($past(addr)));

  assert_read_never_commits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en) |-> (commit_pulse == '0));
endmodule

bind wide_param_sync wps_checker u_wps_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .addr         (addr),
  .params       (params),
  .commit_pulse (commit_pulse)
);

// File: tb/test_wide_param_sync.sv
`timescale 1ns/1ps
module test_wide_param_sync;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [71:0] params;
  logic [2:0]  commit_pulse;

  wide_param_sync i_wide_param_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .params       (params),
    .commit_pulse (commit_pulse)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [71:0] exp_params;
    logic [2:0]  exp_pulse;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 0;

  // independent model of the requirements
  int          base_a [3] = '{8'h34, 8'h40, 8'h50};
  int          nbytes [3] = '{2, 3, 2};
  int          wid    [3] = '{12, 20, 16};
  logic [23:0] m_live [3];
  logic [7:0]  m_stage [3];
  bit          m_active;
  int          m_grp, m_idx;

  function automatic bit lookup(input logic [7:0] a, output int g, output int k);
    g = 0; k = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < nbytes[i]; j++)
        if (int'(a) == base_a[i] + j) begin g = i; k = j; return 1; end
    return 0;
  endfunction

  function automatic logic [71:0] packed_live();
    return {m_live[2], m_live[1], m_live[0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d, input string tag);
    int g, k;
    bit hit, wo;
    logic [2:0]  pls;
    logic [23:0] val;
    logic [7:0]  exp_rd;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    hit = lookup(a, g, k);
    exp_rd = hit ? 8'(m_live[g] >> (8 * (nbytes[g] - 1 - k))) : 8'h00;
    #1;
    if (r) check(rdata == exp_rd, {tag, " R8 rdata"}, 72'(rdata), 72'(exp_rd));
    wo = w && !r;
    pls = '0;
    if (m_active && wo && hit && g == m_grp && k == m_idx) begin
      m_stage[k] = d;
      if (k == nbytes[g] - 1) begin
        val = '0;
        for (int j = 0; j < nbytes[g]; j++) val = (val << 8) | 24'(m_stage[j]);
        val = val & ((24'd1 << wid[g]) - 24'd1);
        m_live[g] = val;
        pls[g] = 1'b1;
        m_active = 0;
      end else begin
        m_idx++;
      end
    end else if (w || r) begin
      m_active = 0;
      if (wo && hit && k == 0) begin
        m_active = 1; m_grp = g; m_idx = 1; m_stage[0] = d;
      end
    end
    q.push_back('{packed_live(), pls, tag});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    access(1, 0, a, d, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    access(0, 1, a, 8'h00, tag);
  endtask
  task automatic idle(input string tag);
    access(0, 0, 8'h00, 8'h00, tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(params == it.exp_params, {it.tag, " params"}, params, it.exp_params);
        check(commit_pulse == it.exp_pulse, {it.tag, " pulse"}, 72'(commit_pulse), 72'(it.exp_pulse));
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_live[0] = 24'h000ABC; m_live[1] = 24'h012345; m_live[2] = 24'h00BEEF;
    m_active = 0; m_grp = 0; m_idx = 0;
    for (int i = 0; i < 3; i++) m_stage[i] = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    check(params == packed_live(), "R1 reset params", params, packed_live());
    check(commit_pulse == 3'b000, "R1 reset pulse", 72'(commit_pulse), 72'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1 first cycle");
    rd(8'h34, "R1 default byte");
    rd(8'h42, "R1 default byte");

    // R2 R4: two-byte group, upper bits of first byte dropped
    wr(8'h34, 8'hF7, "R3 staged");
    wr(8'h35, 8'h9A, "R4 commit g0");
    idle("R4 pulse one cycle");
    // R5: idle cycles inside a sequence
    wr(8'h40, 8'h11, "R5 start g1");
    idle("R5 idle");
    idle("R5 idle");
    wr(8'h41, 8'h22, "R5 mid");
    wr(8'h42, 8'h33, "R2 commit g1 masked");
    // R5: descending order
    wr(8'h35, 8'h55, "R7 lone last");
    wr(8'h34, 8'h66, "R5 start");
    wr(8'h35, 8'h77, "R5 ascending commit");
    // R6: read breaks, returns committed value
    wr(8'h50, 8'hAA, "R6 start g2");
    rd(8'h50, "R6 read break");
    wr(8'h51, 8'hBB, "R6 no commit after read");
    rd(8'h51, "R8 committed byte");
    // R6: other write breaks
    wr(8'h40, 8'h01, "R6 start");
    wr(8'h10, 8'h00, "R6 foreign write");
    wr(8'h41, 8'h02, "R6 orphan");
    wr(8'h42, 8'h03, "R6 no commit");
    // R6: restart on first address
    wr(8'h34, 8'h12, "R6 start");
    wr(8'h34, 8'h34, "R6 restart");
    wr(8'h35, 8'h56, "R6 restart commit");
    // R6: both strobes
    wr(8'h50, 8'h01, "R6 start");
    access(1, 1, 8'h51, 8'h02, "R6 both strobes");
    wr(8'h51, 8'h03, "R7 after abort");
    // R7: lone last writes
    wr(8'h42, 8'hFF, "R7 lone last g1");
    // R8: reads of every address including outside
    for (int a = 8'h30; a < 8'h56; a++) rd(8'(a), "R8 read sweep");
    // back-to-back commits
    wr(8'h50, 8'hC0, "R9 start");
    wr(8'h51, 8'hDE, "R9 commit g2");
    wr(8'h34, 8'h01, "R9 start");
    wr(8'h35, 8'h23, "R9 commit g0");
    // R8: read mid-sequence shows committed, not staged
    wr(8'h40, 8'h99, "R8 stage");
    rd(8'h40, "R8 no staged leak");

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 4) begin
        int g;
        g = $urandom_range(0, 2);
        for (int j = 0; j < nbytes[g]; j++) wr(8'(base_a[g] + j), 8'($urandom), "R4 random commit");
      end else if (sel < 7) begin
        int g, j;
        g = $urandom_range(0, 2);
        j = $urandom_range(0, nbytes[g]);
        wr(8'(base_a[g] + j), 8'($urandom), "R5 random write");
      end else if (sel < 8) begin
        rd(8'($urandom_range(8'h33, 8'h52)), "R6 random read");
      end else if (sel < 9) begin
        idle("R5 random idle");
      end else begin
        access(1, 1, 8'($urandom_range(8'h33, 8'h52)), 8'($urandom), "R6 random both");
      end
    end
    idle("tail");
    idle("tail");
    @(posedge clk);
    #4;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule